// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks the source of each of the two ALU operands in the execute stage of a five-stage in-order integer pipeline. The operand can come from three places: the value read from the register file in decode, the ALU result held in the execute/memory pipeline register, or the write-back value held in the memory/writeback pipeline register. The consumer's two source register numbers come from the instruction word in the decode/execute register. Each producer's destination number is taken from the instruction it holds. The field used for that number depends on whether that instruction is register-format or immediate-format.

A producer supplies an operand only if three things hold: it will write the register file, its destination is not register 0, and its destination equals the operand's source. When both producers match, the younger one wins, which is the one in the execute/memory stage. The write-back value is the loaded word for a memory-to-register instruction and the ALU result otherwise. The block is purely combinational. It contains the select logic and the operand multiplexers. It does not detect the case where an instruction depends on a load immediately ahead of it; that case needs a stall elsewhere.

Top module: `fwd_operand_path`

## Requirements
- R1: A producer's destination number is instruction bits 15:11 when its register-format flag is 1, and bits 20:16 when the flag is 0.
- R2: Operand A's source number is consumer instruction bits 25:21, and operand B's source number is bits 20:16.
- R3: An operand whose source equals the execute/memory destination gets select 2'b10 and the execute/memory ALU result. This needs the execute/memory write flag set and a nonzero destination.
- R4: An operand that matches only the memory/writeback destination gets select 2'b01 and the write-back value. This needs the memory/writeback write flag set and a nonzero destination.
- R5: When both producers qualify for the same operand, the select is 2'b10 and the execute/memory value is used.
- R6: A destination of register 0 never causes forwarding. An operand whose source is 0 always gets select 2'b00.
- R7: A producer whose write flag is 0 never forwards, even when its destination matches.
- R8: The write-back value is the load data when the memory-to-register flag is 1, and the write-back ALU result when the flag is 0.
- R9: With no qualifying match, the select is 2'b00 and the operand equals its register-file value. Select 2'b11 never appears.
- R10: The two operands are selected independently. A and B may take different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cons_instr_i | input | 32 | Instruction word in decode/execute |
| rf_a_i | input | 32 | Register-file value for operand A |
| rf_b_i | input | 32 | Register-file value for operand B |
| exm_instr_i | input | 32 | Instruction word in execute/memory |
| exm_rfmt_i | input | 1 | Execute/memory instruction is register-format |
| exm_we_i | input | 1 | Execute/memory instruction writes a register |
| exm_alu_i | input | 32 | ALU result in execute/memory |
| wb_instr_i | input | 32 | Instruction word in memory/writeback |
| wb_rfmt_i | input | 1 | Memory/writeback instruction is register-format |
| wb_we_i | input | 1 | Memory/writeback instruction writes a register |
| wb_mem2reg_i | input | 1 | Write-back takes load data |
| wb_alu_i | input | 32 | ALU result in memory/writeback |
| wb_load_i | input | 32 | Load data in memory/writeback |
| sel_a_o | output | 2 | Operand A select (00 file, 10 exec/mem, 01 writeback) |
| sel_b_o | output | 2 | Operand B select |
| op_a_o | output | 32 | Operand A to the ALU |
| op_b_o | output | 32 | Operand B to the ALU |

## Verification
Directed patterns cover each case on its own:
- a match only in execute/memory and a match only in memory/writeback, which shows which stage is picked;
- a double match, which shows the younger producer wins;
- a register-0 match and a match with the write flag cleared, which show forwarding is correctly suppressed;
- register-format versus immediate-format producers, where the two destination fields hold different numbers, so using the wrong field is caught.

Randomised cycles then draw register numbers from a small set, so matches on A, on B and on both are frequent. Every select and operand is compared against a behavioural model on every clock.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int INSTR_W = 32;
  localparam int DATA_W  = 32;
  localparam int REG_W   = 5;
  localparam int RD_LSB  = 11;
  localparam int RT_LSB  = RD_LSB + REG_W;
  localparam int RS_LSB  = RT_LSB + REG_W;
  localparam int N_OPS   = 2;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_dest_decode.sv
module fwd_dest_decode
  import fwd_pkg::*;
#(
  parameter int IW = INSTR_W,
  parameter int RW = REG_W
) (
  input  logic [IW-1:0] instr_i,
  input  logic          rfmt_i,
  output logic [RW-1:0] dest_o
);
  always_comb begin
    if (rfmt_i) dest_o = instr_i[RD_LSB +: RW];
    else        dest_o = instr_i[RT_LSB +: RW];
  end
endmodule

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
  import fwd_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic [RW-1:0] src_i,
  input  logic [RW-1:0] exm_dest_i,
  input  logic          exm_we_i,
  input  logic [RW-1:0] wb_dest_i,
  input  logic          wb_we_i,
  output fwd_sel_e      sel_o
);
  logic exm_hit, wb_hit;

  assign exm_hit = exm_we_i && (exm_dest_i != '0) && (exm_dest_i == src_i);
  assign wb_hit  = wb_we_i  && (wb_dest_i  != '0) && (wb_dest_i  == src_i);

  // younger producer takes priority
  always_comb begin
    if (exm_hit)     sel_o = SEL_EXM;
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  fwd_sel_e      sel_i,
  input  logic [DW-1:0] rf_i,
  input  logic [DW-1:0] exm_i,
  input  logic [DW-1:0] wb_i,
  output logic [DW-1:0] op_o
);
  always_comb begin
    unique case (sel_i)
      SEL_EXM: op_o = exm_i;
      SEL_WB:  op_o = wb_i;
      default: op_o = rf_i;
    endcase
  end
endmodule

// File: rtl/fwd_operand_path.sv
module fwd_operand_path
  import fwd_pkg::*;
#(
  parameter int IW = INSTR_W,
  parameter int DW = DATA_W,
  parameter int RW = REG_W
) (
  input  logic [IW-1:0] cons_instr_i,
  input  logic [DW-1:0] rf_a_i,
  input  logic [DW-1:0] rf_b_i,
  input  logic [IW-1:0] exm_instr_i,
  input  logic          exm_rfmt_i,
  input  logic          exm_we_i,
  input  logic [DW-1:0] exm_alu_i,
  input  logic [IW-1:0] wb_instr_i,
  input  logic          wb_rfmt_i,
  input  logic          wb_we_i,
  input  logic          wb_mem2reg_i,
  input  logic [DW-1:0] wb_alu_i,
  input  logic [DW-1:0] wb_load_i,
  output logic [1:0]    sel_a_o,
  output logic [1:0]    sel_b_o,
  output logic [DW-1:0] op_a_o,
  output logic [DW-1:0] op_b_o
);
  logic [RW-1:0] exm_dest, wb_dest;
  logic [DW-1:0] wb_data;
  logic [RW-1:0] src   [N_OPS];
  logic [DW-1:0] rf_v  [N_OPS];
  logic [DW-1:0] op_v  [N_OPS];
  fwd_sel_e      sel_v [N_OPS];

  fwd_dest_decode #(.IW(IW), .RW(RW)) u_exm_dest (
    .instr_i(exm_instr_i), .rfmt_i(exm_rfmt_i), .dest_o(exm_dest)
  );
  fwd_dest_decode #(.IW(IW), .RW(RW)) u_wb_dest (
    .instr_i(wb_instr_i), .rfmt_i(wb_rfmt_i), .dest_o(wb_dest)
  );

  assign wb_data = wb_mem2reg_i ? wb_load_i : wb_alu_i;

  assign src[0]  = cons_instr_i[RS_LSB +: RW];
  assign src[1]  = cons_instr_i[RT_LSB +: RW];
  assign rf_v[0] = rf_a_i;
  assign rf_v[1] = rf_b_i;

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    fwd_src_pick #(.RW(RW)) u_pick (
      .src_i(src[k]), .exm_dest_i(exm_dest), .exm_we_i(exm_we_i),
      .wb_dest_i(wb_dest), .wb_we_i(wb_we_i), .sel_o(sel_v[k])
    );
    fwd_operand_mux #(.DW(DW)) u_mux (
      .sel_i(sel_v[k]), .rf_i(rf_v[k]), .exm_i(exm_alu_i),
      .wb_i(wb_data), .op_o(op_v[k])
    );
  end

  assign sel_a_o = sel_v[0];
  assign sel_b_o = sel_v[1];
  assign op_a_o  = op_v[0];
  assign op_b_o  = op_v[1];
endmodule

// File: rtl/fwd_operand_path_chk.sv
module fwd_operand_path_chk
  import fwd_pkg::*;
#(
  parameter int IW = INSTR_W,
  parameter int DW = DATA_W,
  parameter int RW = REG_W
) (
  input logic [IW-1:0] cons_instr_i,
  input logic [DW-1:0] rf_a_i,
  input logic [DW-1:0] rf_b_i,
  input logic          exm_we_i,
  input logic [DW-1:0] exm_alu_i,
  input logic          wb_we_i,
  input logic [1:0]    sel_a_o,
  input logic [1:0]    sel_b_o,
  input logic [DW-1:0] op_a_o,
  input logic [DW-1:0] op_b_o
);
  always_comb begin
    if (!$isunknown({cons_instr_i, exm_we_i, wb_we_i, sel_a_o, sel_b_o})) begin
      AST_SEL_LEGAL: assert (sel_a_o != 2'b11 && sel_b_o != 2'b11)
        else $error("illegal select"); // R9
      AST_EXM_NEEDS_WE: assert (!((sel_a_o == 2'b10 || sel_b_o == 2'b10) && !exm_we_i))
        else $error("exm forward without write"); // R7
      AST_WB_NEEDS_WE: assert (!((sel_a_o == 2'b01 || sel_b_o == 2'b01) && !wb_we_i))
        else $error("wb forward without write"); // R7
      AST_SRC_ZERO_A: assert (cons_instr_i[RS_LSB +: RW] != '0 || sel_a_o == 2'b00)
        else $error("forward on register 0 (A)"); // R6
      AST_SRC_ZERO_B: assert (cons_instr_i[RT_LSB +: RW] != '0 || sel_b_o == 2'b00)
        else $error("forward on register 0 (B)"); // R6
    end
    if (!$isunknown({sel_a_o, rf_a_i, op_a_o, exm_alu_i})) begin
      AST_RF_PASS_A: assert (sel_a_o != 2'b00 || op_a_o == rf_a_i)
        else $error("A not register value"); // R9
      AST_EXM_PASS_A: assert (sel_a_o != 2'b10 || op_a_o == exm_alu_i)
        else $error("A not exm value"); // R3
    end
    if (!$isunknown({sel_b_o, rf_b_i, op_b_o, exm_alu_i})) begin
      AST_RF_PASS_B: assert (sel_b_o != 2'b00 || op_b_o == rf_b_i)
        else $error("B not register value"); // R9
      AST_EXM_PASS_B: assert (sel_b_o != 2'b10 || op_b_o == exm_alu_i)
        else $error("B not exm value"); // R3
    end
  end
endmodule

bind fwd_operand_path fwd_operand_path_chk #(.IW(IW), .DW(DW), .RW(RW)) u_chk (
  .cons_instr_i(cons_instr_i), .rf_a_i(rf_a_i), .rf_b_i(rf_b_i),
  .exm_we_i(exm_we_i), .exm_alu_i(exm_alu_i), .wb_we_i(wb_we_i),
  .sel_a_o(sel_a_o), .sel_b_o(sel_b_o), .op_a_o(op_a_o), .op_b_o(op_b_o)
);

// File: tb/fwd_operand_path_bench.sv
module fwd_operand_path_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] cons_instr, rf_a, rf_b, exm_instr, exm_alu, wb_instr, wb_alu, wb_load;
  logic        exm_rfmt, exm_we, wb_rfmt, wb_we, wb_mem2reg;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] op_a, op_b;

  fwd_operand_path u_fwd_operand_path (
    .cons_instr_i(cons_instr), .rf_a_i(rf_a), .rf_b_i(rf_b),
    .exm_instr_i(exm_instr), .exm_rfmt_i(exm_rfmt), .exm_we_i(exm_we), .exm_alu_i(exm_alu),
    .wb_instr_i(wb_instr), .wb_rfmt_i(wb_rfmt), .wb_we_i(wb_we), .wb_mem2reg_i(wb_mem2reg),
    .wb_alu_i(wb_alu), .wb_load_i(wb_load),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .op_a_o(op_a), .op_b_o(op_b)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // instruction fields chosen by the bench
  int c_rs, c_rt, x_rd, x_rt, w_rd, w_rt;

  function automatic logic [31:0] mk_instr(int rs, int rt, int rd);
    return 32'(rs) * 32'h0020_0000 + 32'(rt) * 32'h0001_0000 + 32'(rd) * 32'h0000_0800;
  endfunction

  // behavioural reference: 2 = exm, 1 = wb, 0 = file
  function automatic int ref_sel(int src);
    int xd, wd;
    xd = exm_rfmt ? x_rd : x_rt;
    wd = wb_rfmt  ? w_rd : w_rt;
    if (exm_we && xd != 0 && xd == src) return 2;
    if (wb_we && wd != 0 && wd == src) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] ref_op(int s, logic [31:0] rfv);
    if (s == 2) return exm_alu;
    if (s == 1) return wb_mem2reg ? wb_load : wb_alu;
    return rfv;
  endfunction

  task automatic drive();
    cons_instr = mk_instr(c_rs, c_rt, 0);
    exm_instr  = mk_instr(0, x_rt, x_rd);
    wb_instr   = mk_instr(0, w_rt, w_rd);
  endtask

  task automatic check(string tag);
    int ea, eb;
    logic [31:0] oa, ob;
    @(negedge clk);
    ea = ref_sel(c_rs);
    eb = ref_sel(c_rt);
    oa = ref_op(ea, rf_a);
    ob = ref_op(eb, rf_b);
    n_checks++;
    if (int'(sel_a) != ea || op_a !== oa) begin
      n_fail++;
      $display("FAIL %s operand A: sel=%0d op=%h expected sel=%0d op=%h", tag, sel_a, op_a, ea, oa);
    end
    n_checks++;
    if (int'(sel_b) != eb || op_b !== ob) begin
      n_fail++;
      $display("FAIL %s operand B: sel=%0d op=%h expected sel=%0d op=%h", tag, sel_b, op_b, eb, ob);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic base();
    c_rs = 0; c_rt = 0; x_rd = 0; x_rt = 0; w_rd = 0; w_rt = 0;
    exm_rfmt = 0; exm_we = 0; wb_rfmt = 0; wb_we = 0; wb_mem2reg = 0;
    rf_a = 32'hA0A0_0001; rf_b = 32'hB0B0_0002;
    exm_alu = 32'hE0E0_0003; wb_alu = 32'hC0C0_0004; wb_load = 32'hD0D0_0005;
    drive();
  endtask

  initial begin
    base();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset");
    // R3: exm register-format match on A
    c_rs = 7; c_rt = 9; x_rd = 7; x_rt = 9; exm_rfmt = 1; exm_we = 1; drive();
    check("R3");
    // R1: same exm, immediate-format, now dest = rt field (9) hits B
    exm_rfmt = 0; drive();
    check("R1");
    // R4 and R8: wb only, load then alu
    exm_we = 0; w_rd = 3; w_rt = 7; wb_rfmt = 0; wb_we = 1; wb_mem2reg = 1; drive();
    check("R4 R8 load");
    wb_mem2reg = 0; drive();
    check("R8 alu");
    // R5: both match on A
    x_rd = 7; exm_rfmt = 1; exm_we = 1; wb_mem2reg = 1; drive();
    check("R5");
    // R6: destination 0 and source 0
    c_rs = 0; c_rt = 0; x_rd = 0; x_rt = 0; w_rd = 0; w_rt = 0; drive();
    check("R6");
    // R7: matching dest with write flag low
    c_rs = 5; c_rt = 6; x_rd = 5; w_rd = 6; wb_rfmt = 1; exm_we = 0; wb_we = 0; drive();
    check("R7");
    // R10 and R2: A from exm, B from wb
    exm_we = 1; wb_we = 1; drive();
    check("R10 R2");
    // randomised
    for (int i = 0; i < 2000; i++) begin
      c_rs = $urandom_range(0, 3); c_rt = $urandom_range(0, 3);
      x_rd = $urandom_range(0, 3); x_rt = $urandom_range(0, 3);
      w_rd = $urandom_range(0, 3); w_rt = $urandom_range(0, 3);
      exm_rfmt = 1'($urandom); exm_we = 1'($urandom); wb_rfmt = 1'($urandom);
      wb_we = 1'($urandom); wb_mem2reg = 1'($urandom);
      rf_a = $urandom; rf_b = $urandom; exm_alu = $urandom; wb_alu = $urandom; wb_load = $urandom;
      drive();
      check("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule